// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, A and B. Each direction owns a storage register with its own capture clock, so a word can be taken from either bus at any time. A direction input chooses which bus is driven, and an active-low enable can leave both buses undriven. When a bus is driven, a per-direction select chooses between the live value on the other bus and the word stored earlier in that direction's register.

Bus pins are split into separate input, output and output-enable vectors, so the pad ring or an enclosing module builds the tristate drivers. The live pass-through is purely combinational. The stored path reads a register that only changes on its own clock edge.

Top module: `regBusXcvr`

## Requirements
- R1: On every rising edge of `clkAtoB`, `busAIn` is stored in the A-side register. This happens in every output state, including while bus A is driven.
- R2: On every rising edge of `clkBtoA`, `busBIn` is stored in the B-side register. This happens in every output state, including while bus B is driven.
- R3: While `outEnN` is 1, both `busAOe` and `busBOe` are all zeros (isolation). Both registers keep capturing and keep their contents.
- R4: `busAOe` and `busBOe` are never nonzero at the same time.
- R5: With `outEnN`=0 and `dirAtoB`=0, `busAOe` is all ones. With `selStoredBA`=0, `busAOut` equals `busBIn` in the same cycle, with no register stage.
- R6: With `outEnN`=0, `dirAtoB`=0 and `selStoredBA`=1, `busAOut` equals the B-side register contents.
- R7: With `outEnN`=0 and `dirAtoB`=1, `busBOe` is all ones. With `selStoredAB`=0, `busBOut` equals `busAIn` in the same cycle.
- R8: With `outEnN`=0, `dirAtoB`=1 and `selStoredAB`=1, `busBOut` equals the A-side register contents.
- R9: While `rstN` is 0, both registers clear to zero at once and both enable vectors are all zeros. After release, a stored read returns zero until the next capture.
- R10: An undriven bus presents all zeros on its output vector.
- R11: The select of the direction that is not driven has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkAtoB | input | 1 | Capture clock of the A-side register (rising edge) |
| clkBtoA | input | 1 | Capture clock of the B-side register (rising edge) |
| rstN | input | 1 | Asynchronous reset, active low |
| outEnN | input | 1 | Output enable, active low; 1 isolates both buses |
| dirAtoB | input | 1 | 1 drives bus B from the A side, 0 drives bus A from the B side |
| selStoredAB | input | 1 | Bus B source: 1 = A-side register, 0 = live bus A |
| selStoredBA | input | 1 | Bus A source: 1 = B-side register, 0 = live bus B |
| busAIn | input | W | Value seen on bus A pins |
| busAOut | output | W | Value to drive onto bus A |
| busAOe | output | W | Per-bit drive enable for bus A |
| busBIn | input | W | Value seen on bus B pins |
| busBOut | output | W | Value to drive onto bus B |
| busBOe | output | W | Per-bit drive enable for bus B |

## Verification
The main function is tried in all eight operating modes: capture A only, capture B only, capture both, isolation hold, and live or stored transfer in each direction. The words on the two buses always differ from each other and from the stored words, so each output value shows which source was selected. Some steps capture while the opposite bus is driven, and these show that capture does not depend on the output state. Other steps hold the enable high and change only the inputs, which separates holding from capturing. Some steps flip the select of the undriven direction. A reset applied in mid-run, while a drive mode is requested, shows that enables are suppressed and stored reads return zero.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
  // Strobes from the mode decoder to the datapath
  typedef struct packed {
    logic driveA;     // bus A receives data
    logic driveB;     // bus B receives data
    logic storedToA;  // bus A takes the B-side register
    logic storedToB;  // bus B takes the A-side register
  } xcvrCtl_t;
endpackage

// File: rtl/xcvrCtrl.sv
`timescale 1ns/1ps
module xcvrCtrl
  import xcvr_pkg::*;
(
  input  logic     rstN,
  input  logic     outEnN,
  input  logic     dirAtoB,
  input  logic     selStoredAB,
  input  logic     selStoredBA,
  output xcvrCtl_t ctl
);
  logic enabled;

  assign enabled = rstN && !outEnN;

  always_comb begin
    ctl.driveA    = enabled && !dirAtoB;
    ctl.driveB    = enabled && dirAtoB;
    ctl.storedToA = selStoredBA;
    ctl.storedToB = selStoredAB;
  end
endmodule

// File: rtl/xcvrDatapath.sv
`timescale 1ns/1ps
module xcvrDatapath
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clkAtoB,
  input  logic         clkBtoA,
  input  logic         rstN,
  input  xcvrCtl_t     ctl,
  input  logic [W-1:0] busAIn,
  input  logic [W-1:0] busBIn,
  output logic [W-1:0] busAOut,
  output logic [W-1:0] busAOe,
  output logic [W-1:0] busBOut,
  output logic [W-1:0] busBOe
);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] storeA;
  logic [W-1:0] storeB;

  // A-side register, own clock, capture always enabled
  always_ff @(posedge clkAtoB or negedge rstN) begin
    if (!rstN) storeA <= ZERO;
    else       storeA <= busAIn;
  end

  // B-side register, own clock, capture always enabled
  always_ff @(posedge clkBtoA or negedge rstN) begin
    if (!rstN) storeB <= ZERO;
    else       storeB <= busBIn;
  end

  // Output muxes: live pass-through or stored copy, zero when undriven
  always_comb begin
    busAOut = ZERO;
    busBOut = ZERO;
    if (ctl.driveA) busAOut = ctl.storedToA ? storeB : busBIn;
    if (ctl.driveB) busBOut = ctl.storedToB ? storeA : busAIn;
  end

  assign busAOe = {W{ctl.driveA}};
  assign busBOe = {W{ctl.driveB}};

  // R1: A-side register holds the bus A word from the previous edge
  a_r1_capture_a: assert property (@(posedge clkAtoB) disable iff (!rstN)
    1'b1 |=> (storeA == $past(busAIn)));

  // R2: B-side register holds the bus B word from the previous edge
  a_r2_capture_b: assert property (@(posedge clkBtoA) disable iff (!rstN)
    1'b1 |=> (storeB == $past(busBIn)));

  // R6 / R8: stored paths present the registers
  always_comb begin
    if (ctl.driveA && ctl.storedToA) a_r6_stored_b: assert (busAOut == storeB);
    if (ctl.driveB && ctl.storedToB) a_r8_stored_a: assert (busBOut == storeA);
  end
endmodule

// File: rtl/regBusXcvr.sv
`timescale 1ns/1ps
module regBusXcvr
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clkAtoB,
  input  logic         clkBtoA,
  input  logic         rstN,
  input  logic         outEnN,
  input  logic         dirAtoB,
  input  logic         selStoredAB,
  input  logic         selStoredBA,
  input  logic [W-1:0] busAIn,
  output logic [W-1:0] busAOut,
  output logic [W-1:0] busAOe,
  input  logic [W-1:0] busBIn,
  output logic [W-1:0] busBOut,
  output logic [W-1:0] busBOe
);
  xcvrCtl_t ctl;

  xcvrCtrl i_ctrl (
    .rstN        (rstN),
    .outEnN      (outEnN),
    .dirAtoB     (dirAtoB),
    .selStoredAB (selStoredAB),
    .selStoredBA (selStoredBA),
    .ctl         (ctl)
  );

  xcvrDatapath #(.W(W)) i_dp (
    .clkAtoB (clkAtoB),
    .clkBtoA (clkBtoA),
    .rstN    (rstN),
    .ctl     (ctl),
    .busAIn  (busAIn),
    .busBIn  (busBIn),
    .busAOut (busAOut),
    .busAOe  (busAOe),
    .busBOut (busBOut),
    .busBOe  (busBOe)
  );

  // Port-level checks across control and datapath
  always_comb begin
    a_r4_one_bus: assert (!((|busAOe) && (|busBOe)));
    if (!rstN || outEnN) a_r3_isolated: assert (busAOe == '0 && busBOe == '0);
    if (rstN && !outEnN && !dirAtoB && !selStoredBA)
      a_r5_live_to_a: assert (busAOut == busBIn && busAOe == '1);
    if (rstN && !outEnN && dirAtoB && !selStoredAB)
      a_r7_live_to_b: assert (busBOut == busAIn && busBOe == '1);
    if (busAOe == '0) a_r10_idle_a: assert (busAOut == '0);
    if (busBOe == '0) a_r10_idle_b: assert (busBOut == '0);
  end
endmodule

// File: tb/test_regBusXcvr.sv
`timescale 1ns/1ps
module test_regBusXcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;  // 200 MHz

  logic clkAtoB = 1'b0, clkBtoA = 1'b0, rstN = 1'b0;
  logic outEnN = 1'b1, dirAtoB = 1'b0, selStoredAB = 1'b0, selStoredBA = 1'b0;
  logic [W-1:0] busAIn = '0, busBIn = '0;
  logic [W-1:0] busAOut, busAOe, busBOut, busBOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  regBusXcvr #(.W(W)) i_regBusXcvr (
    .clkAtoB(clkAtoB), .clkBtoA(clkBtoA), .rstN(rstN), .outEnN(outEnN),
    .dirAtoB(dirAtoB), .selStoredAB(selStoredAB), .selStoredBA(selStoredBA),
    .busAIn(busAIn), .busAOut(busAOut), .busAOe(busAOe),
    .busBIn(busBIn), .busBOut(busBOut), .busBOe(busBOe));

  typedef struct packed {
    logic       oeN, dir, sab, sba, pa, pb;
    logic [7:0] a, b, expA, expB;
    logic       expAOe, expBOe;
    logic [7:0] req;
  } vec_t;

  // oeN dir sab sba pa pb  a  b  expAOut expBOut aOe bOe req
  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1,0,0,0,1,1, 8'h11,8'h22, 8'h00,8'h00, 0,0, 8'd3},  // store both while isolated
    '{0,0,0,0,0,0, 8'h33,8'h44, 8'h44,8'h00, 1,0, 8'd5},  // live B to A
    '{0,0,0,1,0,0, 8'h33,8'h44, 8'h22,8'h00, 1,0, 8'd6},  // stored B to A
    '{0,1,0,0,0,0, 8'h55,8'h66, 8'h00,8'h55, 0,1, 8'd7},  // live A to B
    '{0,1,1,0,0,0, 8'h55,8'h66, 8'h00,8'h11, 0,1, 8'd8},  // stored A to B
    '{0,1,1,0,1,0, 8'h77,8'h88, 8'h00,8'h77, 0,1, 8'd1},  // store A only, B driven
    '{0,0,0,1,0,1, 8'h99,8'hAA, 8'hAA,8'h00, 1,0, 8'd2},  // store B only, A driven
    '{1,0,0,1,1,1, 8'h5A,8'hA5, 8'h00,8'h00, 0,0, 8'd3},  // store both, isolated
    '{0,0,0,1,0,0, 8'h00,8'hFF, 8'hA5,8'h00, 1,0, 8'd6},
    '{0,1,1,0,0,0, 8'h00,8'hFF, 8'h00,8'h5A, 0,1, 8'd8},
    '{0,1,0,1,0,0, 8'hC3,8'h3C, 8'h00,8'hC3, 0,1, 8'd11}, // sba ignored
    '{0,0,1,0,0,0, 8'hF0,8'h0F, 8'h0F,8'h00, 1,0, 8'd11}, // sab ignored
    '{1,1,1,0,0,0, 8'h12,8'h34, 8'h00,8'h00, 0,0, 8'd10}, // isolation hold
    '{0,1,1,0,0,0, 8'h12,8'h34, 8'h00,8'h5A, 0,1, 8'd3}   // register kept through hold
  };

  function automatic string reqName(input logic [7:0] n);
    case (n)
      8'd1:  return "R1";
      8'd2:  return "R2";
      8'd3:  return "R3";
      8'd5:  return "R5";
      8'd6:  return "R6";
      8'd7:  return "R7";
      8'd8:  return "R8";
      8'd10: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkExcl();
    checks++;
    if ((|busAOe) && (|busBOe)) begin
      errors++;
      $display("FAIL R4 both enables: actual %h/%h expected one zero", busAOe, busBOe);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    outEnN = v.oeN; dirAtoB = v.dir; selStoredAB = v.sab; selStoredBA = v.sba;
    busAIn = v.a; busBIn = v.b;
    #0.5;
    clkAtoB = v.pa; clkBtoA = v.pb;
    #0.5;
    clkAtoB = 1'b0; clkBtoA = 1'b0;
    #0.5;
  endtask

  initial begin
    // R9: reset state with a drive mode requested
    outEnN = 1'b0; dirAtoB = 1'b0; selStoredBA = 1'b1;
    busAIn = 8'hE7; busBIn = 8'h7E;
    repeat (2) @(negedge clk);
    check("R9", "busAOe in reset", busAOe, 8'h00);
    check("R9", "busBOe in reset", busBOe, 8'h00);
    check("R10", "busAOut in reset", busAOut, 8'h00);
    checkExcl();
    rstN = 1'b1;
    @(negedge clk);
    check("R9", "stored B after reset", busAOut, 8'h00);
    check("R5", "busAOe driven", busAOe, 8'hFF);

    foreach (VECS[i]) begin
      apply(VECS[i]);
      check(reqName(VECS[i].req), "busAOut", busAOut, VECS[i].expA);
      check(reqName(VECS[i].req), "busBOut", busBOut, VECS[i].expB);
      check(reqName(VECS[i].req), "busAOe", busAOe, {W{VECS[i].expAOe}});
      check(reqName(VECS[i].req), "busBOe", busBOe, {W{VECS[i].expBOe}});
      checkExcl();
    end

    // R5: live path follows input with no clock
    @(negedge clk);
    outEnN = 1'b0; dirAtoB = 1'b0; selStoredBA = 1'b0; busBIn = 8'h81;
    #0.5;
    check("R5", "live follow 1", busAOut, 8'h81);
    busBIn = 8'h18;
    #0.5;
    check("R5", "live follow 2", busAOut, 8'h18);

    // R9: mid-run reset clears both registers
    @(negedge clk);
    rstN = 1'b0;
    #0.5;
    check("R9", "busAOe mid reset", busAOe, 8'h00);
    check("R10", "busAOut mid reset", busAOut, 8'h00);
    @(negedge clk);
    rstN = 1'b1; dirAtoB = 1'b1; selStoredAB = 1'b1;
    #0.5;
    check("R9", "stored A cleared", busBOut, 8'h00);
    dirAtoB = 1'b0; selStoredBA = 1'b1;
    #0.5;
    check("R9", "stored B cleared", busAOut, 8'h00);
    checkExcl();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule